// File: doc/BRIEF.md
# Serial Audio Link Inbound Frame Deframer

This block sits on the controller side of a serial audio link and takes apart the frames a codec sends back. It runs entirely on the falling edge of the link bit clock, because the codec changes its serial data on the rising edge. The controller generates the frame sync itself and passes it to this block. The deframer watches that sync for a rising edge to find where each frame starts. From there it shifts in one 16-bit tag slot followed by twelve 20-bit data slots, 256 bits per frame.

When a data slot is complete, the block raises a one-cycle strobe. Alongside the strobe it presents the slot number, the 20-bit payload and that slot's valid bit, taken from the tag word of the same frame. When the last slot is in, a frame-done strobe fires and the frame's tag word is published. Slot 1 carries the echoed status address and slot 2 carries the status read data. Each of these is copied into its own held output only when its tag bit is set.

If sync rises again before a frame has finished, the unfinished frame is abandoned, a new frame begins at that edge, and a sticky framing-error flag is raised.

Top module: `aclink_rx_deframer`

## Requirements
- R1: While reset is asserted, all strobes, both status-valid pulses, the error flag, the tag word and the held status registers read zero.
- R2: Serial data and sync are sampled on the falling edge of the bit clock, and every output changes only at a falling edge.
- R3: The first falling-edge sample at which sync is high after having been low is frame bit 0. If sync stays high after that, no new frame is started.
- R4: Frame bits 0 to 15 form the tag word, with the first bit as bit 15. The tag word is output on `tag_word_o` together with frame-done and is held until the next frame-done.
- R5: A data slot is complete after every further 20 bits (frame bits 16+20(k-1) to 35+20(k-1) for slot k). One cycle after the slot's last sample, `slot_stb_o` is high for one cycle, with `slot_idx_o` equal to k (1 to 12) and `slot_data_o` holding the 20 bits, first-received bit as bit 19.
- R6: `slot_tag_o` alongside a slot strobe equals tag-word bit (15 − k) of the same frame.
- R7: `frame_done_o` is high for exactly one cycle, in the same cycle as the slot-12 strobe, after 256 bits. After that the block ignores the serial input until the next sync rising edge.
- R8: A sync rising edge seen when 1 to 255 bits of the current frame have been taken discards that frame, so no further strobes come from it. The edge restarts at frame bit 0 and sets `frame_err_o`, which stays high until reset. A rising edge arriving after bit 255, or while idle, does not set the flag.
- R9: When slot 1 completes with its tag bit set, `stat_addr_o` loads the slot payload and `stat_addr_vld_o` pulses with the strobe. An untagged slot 1 leaves `stat_addr_o` unchanged and gives no pulse.
- R10: When slot 2 completes with its tag bit set, `stat_data_o` loads the payload and `stat_data_vld_o` pulses with the strobe. An untagged slot 2 leaves it unchanged and gives no pulse.
- R11: While no frame is in progress, serial input activity produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Link bit clock; all sampling on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Frame sync from the local controller |
| sdin_i | input | 1 | Serial data from the codec |
| slot_stb_o | output | 1 | One-cycle pulse when a data slot completes |
| slot_idx_o | output | 4 | Number of the completed slot, 1 to 12 |
| slot_data_o | output | 20 | Payload of the completed slot |
| slot_tag_o | output | 1 | Valid bit of the completed slot |
| frame_done_o | output | 1 | One-cycle pulse when all 256 bits are in |
| tag_word_o | output | 16 | Tag word of the last finished frame |
| frame_err_o | output | 1 | Sticky flag for a frame cut short by sync |
| stat_addr_o | output | 20 | Last tagged slot-1 payload |
| stat_addr_vld_o | output | 1 | Pulse when `stat_addr_o` is loaded |
| stat_data_o | output | 20 | Last tagged slot-2 payload |
| stat_data_vld_o | output | 1 | Pulse when `stat_data_o` is loaded |

## Verification
The assertions assume that sync and serial data are stable around each falling edge, and that a frame takes at least 256 bit times unless it is deliberately cut short. Slot completions are therefore always 20 samples apart. The bench drives both inputs shortly after the rising edge, so every falling edge sees settled values. It sends sender-correct frames in which untagged slots are zero-filled. Truncation, back-to-back starts, long sync pulses and noisy idle gaps are introduced only as separate, deliberate episodes.

// File: rtl/aclink_rx_deframer.sv
module aclink_rx_deframer #(
  parameter int TAG_W   = 16,
  parameter int SLOT_W  = 20,
  parameter int N_SLOTS = 12
) (
  input  logic                  bclk_i,
  input  logic                  rst_n,
  input  logic                  sync_i,
  input  logic                  sdin_i,
  output logic                  slot_stb_o,
  output logic [3:0]            slot_idx_o,
  output logic [SLOT_W-1:0]     slot_data_o,
  output logic                  slot_tag_o,
  output logic                  frame_done_o,
  output logic [TAG_W-1:0]      tag_word_o,
  output logic                  frame_err_o,
  output logic [SLOT_W-1:0]     stat_addr_o,
  output logic                  stat_addr_vld_o,
  output logic [SLOT_W-1:0]     stat_data_o,
  output logic                  stat_data_vld_o
);
  localparam int FRAME_LEN = TAG_W + SLOT_W * N_SLOTS;
  localparam int CW = $clog2(FRAME_LEN + 1);
  localparam int BW = $clog2(SLOT_W);

  logic              sync_q, active;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bpos;
  logic [3:0]        sidx;
  logic [SLOT_W-1:0] sr;
  logic [TAG_W-1:0]  tagw;

  wire               rise     = sync_i & ~sync_q;
  wire               take     = rise | active;
  wire [CW-1:0]      idx      = rise ? '0 : cnt;
  wire               in_data  = idx >= CW'(TAG_W);
  wire [SLOT_W-1:0]  word     = {sr[SLOT_W-2:0], sdin_i};
  wire               slot_end = take && in_data && (bpos == BW'(SLOT_W-1));
  wire               last     = slot_end && (sidx == 4'(N_SLOTS));
  wire [TAG_W-1:0]   tag_sh   = tagw << sidx;
  wire               cur_tag  = tag_sh[TAG_W-1];

  always_ff @(negedge bclk_i or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
      bpos   <= '0;
      sidx   <= '0;
      sr     <= '0;
      tagw   <= '0;
    end else begin
      sync_q <= sync_i;
      if (take) sr <= word;
      if (take && idx == CW'(TAG_W-1)) tagw <= word[TAG_W-1:0];
      if (rise) begin
        active <= 1'b1;
        cnt    <= CW'(1);
        bpos   <= '0;
        sidx   <= 4'd1;
      end else if (active) begin
        cnt <= cnt + 1'b1;
        if (in_data) bpos <= slot_end ? '0 : bpos + 1'b1;
        if (slot_end) sidx <= sidx + 4'd1;
        if (last) active <= 1'b0;
      end
    end
  end

  always_ff @(negedge bclk_i or negedge rst_n) begin
    if (!rst_n) begin
      slot_stb_o      <= 1'b0;
      slot_idx_o      <= '0;
      slot_data_o     <= '0;
      slot_tag_o      <= 1'b0;
      frame_done_o    <= 1'b0;
      tag_word_o      <= '0;
      frame_err_o     <= 1'b0;
      stat_addr_o     <= '0;
      stat_addr_vld_o <= 1'b0;
      stat_data_o     <= '0;
      stat_data_vld_o <= 1'b0;
    end else begin
      slot_stb_o      <= slot_end;
      frame_done_o    <= last;
      stat_addr_vld_o <= slot_end && cur_tag && sidx == 4'd1;
      stat_data_vld_o <= slot_end && cur_tag && sidx == 4'd2;
      if (slot_end) begin
        slot_idx_o  <= sidx;
        slot_data_o <= word;
        slot_tag_o  <= cur_tag;
      end
      if (last) tag_word_o <= tagw;
      if (rise && active) frame_err_o <= 1'b1;
      if (slot_end && cur_tag && sidx == 4'd1) stat_addr_o <= word;
      if (slot_end && cur_tag && sidx == 4'd2) stat_data_o <= word;
    end
  end

  a_r5_idx_range: assert property (@(negedge bclk_i) disable iff (!rst_n)
    slot_stb_o |-> (slot_idx_o >= 4'd1 && slot_idx_o <= 4'(N_SLOTS)));

  a_r5_stb_single: assert property (@(negedge bclk_i) disable iff (!rst_n)
    slot_stb_o |=> !slot_stb_o);

  a_r7_done_with_last: assert property (@(negedge bclk_i) disable iff (!rst_n)
    frame_done_o |-> (slot_stb_o && slot_idx_o == 4'(N_SLOTS)));

  a_r8_err_sticky: assert property (@(negedge bclk_i) disable iff (!rst_n)
    frame_err_o |=> frame_err_o);

  a_r9_addr_vld: assert property (@(negedge bclk_i) disable iff (!rst_n)
    stat_addr_vld_o |-> (slot_stb_o && slot_tag_o && slot_idx_o == 4'd1));

  a_r10_data_vld: assert property (@(negedge bclk_i) disable iff (!rst_n)
    stat_data_vld_o |-> (slot_stb_o && slot_tag_o && slot_idx_o == 4'd2));

  a_r9_addr_hold: assert property (@(negedge bclk_i) disable iff (!rst_n)
    !stat_addr_vld_o && $past(rst_n) |-> $stable(stat_addr_o));
endmodule

// File: tb/aclink_rx_deframer_tb_top.sv
module aclink_rx_deframer_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, sync_i = 1'b0, sdin_i = 1'b0;
  logic slot_stb_o, slot_tag_o, frame_done_o, frame_err_o, stat_addr_vld_o, stat_data_vld_o;
  logic [3:0]  slot_idx_o;
  logic [19:0] slot_data_o, stat_addr_o, stat_data_o;
  logic [15:0] tag_word_o;

  aclink_rx_deframer dut_i (
    .bclk_i(clk), .rst_n(rst_n), .sync_i(sync_i), .sdin_i(sdin_i),
    .slot_stb_o(slot_stb_o), .slot_idx_o(slot_idx_o), .slot_data_o(slot_data_o),
    .slot_tag_o(slot_tag_o), .frame_done_o(frame_done_o), .tag_word_o(tag_word_o),
    .frame_err_o(frame_err_o), .stat_addr_o(stat_addr_o), .stat_addr_vld_o(stat_addr_vld_o),
    .stat_data_o(stat_data_o), .stat_data_vld_o(stat_data_vld_o));

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // reference model state
  int fb[256];
  int pos = -1;
  bit prev_s = 0, e_err = 0;
  logic [15:0] e_tagw = '0;
  logic [19:0] e_sa = '0, e_sd = '0;
  bit sampled_ok = 0;

  always @(negedge clk) sampled_ok <= rst_n;

  always @(posedge clk) begin
    if (!rst_n) begin
      pos = -1; prev_s = 0; e_err = 0; e_tagw = '0; e_sa = '0; e_sd = '0;
      chk("R1", "stb", slot_stb_o, 0);
      chk("R1", "done", frame_done_o, 0);
      chk("R1", "err", frame_err_o, 0);
      chk("R1", "tagw", tag_word_o, 0);
      chk("R1", "stat", {stat_addr_vld_o, stat_data_vld_o, stat_addr_o, stat_data_o}, 0);
    end else if (sampled_ok) begin
      bit rise, e_stb, e_done, e_sav, e_sdv, e_tag;
      int k;
      logic [19:0] w;
      logic [15:0] tw;
      e_stb = 0; e_done = 0; e_sav = 0; e_sdv = 0; e_tag = 0; k = 0; w = '0;
      rise = sync_i && !prev_s;
      prev_s = sync_i;
      if (rise) begin
        if (pos > 0) e_err = 1;
        pos = 0;
      end
      if (pos >= 0) begin
        fb[pos] = sdin_i;
        pos++;
        if (pos > 16 && (pos - 16) % 20 == 0) begin
          k = (pos - 16) / 20;
          for (int i = 0; i < 20; i++) w[19-i] = fb[pos-20+i][0];
          for (int i = 0; i < 16; i++) tw[15-i] = fb[i][0];
          e_stb = 1;
          e_tag = tw[15-k];
          if (k == 1 && e_tag) begin e_sa = w; e_sav = 1; end
          if (k == 2 && e_tag) begin e_sd = w; e_sdv = 1; end
          if (k == 12) begin e_done = 1; e_tagw = tw; pos = -1; end
        end
      end
      chk("R5", "slot_stb", slot_stb_o, e_stb);
      if (e_stb && slot_stb_o) begin
        chk("R5", "slot_idx", slot_idx_o, k);
        chk("R2", "slot_data", slot_data_o, w);
        chk("R6", "slot_tag", slot_tag_o, e_tag);
      end
      chk("R7", "frame_done", frame_done_o, e_done);
      chk("R4", "tag_word", tag_word_o, e_tagw);
      chk("R8", "frame_err", frame_err_o, e_err);
      chk("R9", "stat_addr_vld", stat_addr_vld_o, e_sav);
      chk("R9", "stat_addr", stat_addr_o, e_sa);
      chk("R10", "stat_data_vld", stat_data_vld_o, e_sdv);
      chk("R10", "stat_data", stat_data_o, e_sd);
    end
  end

  task automatic drive(input bit s, input bit d);
    @(posedge clk); #1;
    sync_i = s; sdin_i = d;
  endtask

  // R3 R11: frame with given tags, cut length, sync length and noisy idle gap
  task automatic frame(input logic [15:0] tags, input int cut, input int sync_len, input int idle);
    logic [255:0] bits;
    bits[255:240] = tags;
    for (int k = 1; k <= 12; k++) begin
      logic [19:0] v;
      v = tags[15-k] ? 20'($urandom) : 20'h0;
      bits[239-20*(k-1) -: 20] = v;
    end
    for (int i = 0; i < cut; i++) drive(i < sync_len, bits[255-i]);
    for (int i = 0; i < idle; i++) drive(1'b0, 1'($urandom));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(posedge clk); #1; rst_n = 1'b1;
    frame(16'hFFF8, 256, 16, 6);
    frame(16'hC000, 256, 16, 4);
    frame(16'hA000, 256, 16, 3);
    frame(16'h9555, 256, 16, 0);
    frame(16'hEAAA, 256, 40, 2);
    frame(16'hFFFF, 100, 16, 0);
    frame(16'hE000, 256, 16, 30);
    @(posedge clk); #1; rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(posedge clk); #1; rst_n = 1'b1;
    frame(16'h6F00, 256, 16, 5);
    frame(16'hFFF8, 8, 8, 0);
    frame(16'hC800, 256, 16, 5);
    repeat (3) @(posedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule